// File: doc/BRIEF.md
# Reference Clock Rate Classifier

This block decides which of seven standard telecom clock rates a reference input carries. It counts rising edges of the reference, after a two-flop synchroniser, over a gate window that the local master clock times. At the end of each window it compares the count with a tolerance band for each rate. The result is a 3-bit rate code with a valid flag. When a newly detected valid rate differs from the last valid rate seen, the block sends a single-cycle pulse. Downstream activity logic uses that pulse to drop the reference at once.

The master clock runs at either 10 MHz or 20 MHz, selected by `mclk_fast`. The window lasts `GATE_CYC_10M` master cycles in the slow case and twice that in the fast case, so it always covers the same time span. The tolerance bands therefore do not depend on the select. `RATE_DIV` scales the nominal edge counts for references whose rate has been divided down, which keeps every rate below half the master rate.

A small state machine sequences the work. After reset it sits in `ST_ARM` for one cycle, which loads the timer and clears the counter. It then moves to `ST_GATE`, where edges are counted for the whole window. On the timer's last cycle it goes to `ST_JUDGE`. That single cycle registers the verdict, reloads the timer and clears the counter, and the machine returns to `ST_GATE`. The transitions are:
- ARM→GATE: always.
- GATE→GATE: until the timer's last cycle.
- GATE→JUDGE: on the timer's last cycle.
- JUDGE→GATE: always.

Top module: `refclk_rate_classifier`

## Requirements
- R1: While reset is asserted, and directly after it is released, `rate_code` is 0 and both `rate_valid` and `rate_changed` are 0.
- R2: Take N = `GATE_CYC_10M` when `mclk_fast` is 0 and N = 2·`GATE_CYC_10M` when it is 1. The value of `mclk_fast` is sampled as each window starts. The first verdict appears on the outputs after the (N+2)-th rising clock edge following reset release. Each later verdict appears exactly N+1 edges after the one before.
- R3: The rate codes are 1 = 8 kHz, 2 = 64 kHz, 3 = 1.544 MHz, 4 = 2.048 MHz, 5 = 19.44 MHz, 6 = 38.88 MHz and 7 = 77.76 MHz. A window count inside the band of code k gives `rate_code` = k and `rate_valid` = 1. If bands overlap, the lowest code wins.
- R4: The nominal count for a rate is floor(rate_Hz · `GATE_CYC_10M` / (10^7 · `RATE_DIV`)). A band spans the nominal count ± max(1, floor(nominal/100)). A reference 0.5 % above a nominal rate is accepted, and one 3 % below it is rejected.
- R5: A count that falls in no band gives code 0 with `rate_valid` = 0. This covers no reference at all, a rate between classes, and a class whose nominal count is below 4, which is disabled.
- R6: `rate_code` and `rate_valid` change only at the verdict edge of a window and hold their values in every other cycle.
- R7: `rate_changed` is high for exactly one cycle, together with the verdict, when a valid code differs from the last valid code. It stays low on the first valid verdict after reset and on any repeat of the same code.
- R8: Invalid verdicts leave the remembered last valid code unchanged. The same rate returning after a gap gives no pulse, and a different rate after a gap gives one.
- R9: With `mclk_fast` = 1, each rate is classified to the same code as in the 10 MHz case.
- R10: Only rising edges of the synchronised reference are counted. The counter saturates at its maximum value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock, 10 MHz or 20 MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclk_fast | input | 1 | Master-rate select: 0 for 10 MHz, 1 for 20 MHz |
| ref_in | input | 1 | Reference clock, asynchronous to `clk_m` |
| rate_code | output | 3 | Detected rate class; 0 when none |
| rate_valid | output | 1 | High while `rate_code` holds a matched class |
| rate_changed | output | 1 | One-cycle pulse when the valid class changes |

## Verification
Every verdict is due at a fixed edge: edge N+2 after reset release, then every N+1 edges. A change pulse must appear at that same edge and be gone one edge later. The scoreboard monitor keeps a cycle count from reset release. On the falling edge just before each verdict edge it checks that the previous outputs still hold. On the falling edge just after, it pops and compares the queued expectation. It then checks again one cycle later for the pulse's end, and at mid-window for stability. The driver changes the reference only on the falling edge right after a verdict. It leaves the reference stopped for a whole window between rates whose counts are small, so that no stray edge from the old rate can move a count outside its band.

// File: rtl/rate_cls_pkg.sv
package rate_cls_pkg;

    localparam int     NUM_CLASSES   = 7;
    localparam int     CODE_W        = 3;
    localparam longint SLOW_MASTER_HZ = 64'sd10_000_000;
    localparam longint MIN_NOMINAL   = 64'sd4;

    typedef enum logic [1:0] {
        ST_ARM   = 2'd0,
        ST_GATE  = 2'd1,
        ST_JUDGE = 2'd2
    } win_state_t;

    typedef logic [CODE_W-1:0] rate_code_t;

    // Rate in Hz carried by each class code; code 0 is "none".
    function automatic longint class_hz(input int idx);
        case (idx)
            1:       return 64'sd8_000;
            2:       return 64'sd64_000;
            3:       return 64'sd1_544_000;
            4:       return 64'sd2_048_000;
            5:       return 64'sd19_440_000;
            6:       return 64'sd38_880_000;
            7:       return 64'sd77_760_000;
            default: return 64'sd0;
        endcase
    endfunction

    // Expected rising edges in one window (window time is fixed by the slow-clock length).
    function automatic longint nominal_count(input int idx, input longint gate_cyc,
                                             input longint div);
        return (class_hz(idx) * gate_cyc) / (SLOW_MASTER_HZ * div);
    endfunction

    // Band half-width: one percent of nominal, never less than one count.
    function automatic longint band_margin(input longint nom);
        return ((nom / 64'sd100) > 64'sd0) ? (nom / 64'sd100) : 64'sd1;
    endfunction

endpackage

// File: rtl/rate_edge_counter.sv
module rate_edge_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_async,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] count
);

    localparam int SYNC_STAGES = 3;   // two metastability flops plus one history flop

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ref_async};
        end
    end

    assign rise = sync_q[SYNC_STAGES-2] & ~sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (en && rise && (count != '1)) begin
            count <= count + 1'b1;
        end
    end

    // R10: outside the gate the count is frozen
    assert_count_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(count));

    // R10: the count never jumps by more than one edge per cycle
    assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> ((count == $past(count)) || (count == $past(count) + 1'b1)));

endmodule

// File: rtl/rate_gate_timer.sv
module rate_gate_timer #(
    parameter int SLOW_CYC = 10000,
    parameter int FAST_CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    input  logic fast,
    output logic last
);

    localparam int TW = (FAST_CYC > 1) ? $clog2(FAST_CYC) : 1;

    logic [TW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= fast ? TW'(FAST_CYC - 1) : TW'(SLOW_CYC - 1);
        end else if (run && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign last = run && (remain == '0);

    // R2: the terminal cycle is never repeated back to back
    assert_last_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !last);

    // R2: loading and counting are never requested together
    assert_load_run_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && run));

endmodule

// File: rtl/rate_band_match.sv
module rate_band_match
    import rate_cls_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int GATE_CYC = 10000,
    parameter int RATE_DIV = 1
) (
    input  logic [CNT_W-1:0] count,
    output rate_code_t       cls,
    output logic             hit
);

    logic [NUM_CLASSES:1] in_band;
    logic [63:0]          cnt_wide;

    assign cnt_wide = 64'(count);

    for (genvar k = 1; k <= NUM_CLASSES; k++) begin : g_band
        localparam longint NOM    = nominal_count(k, longint'(GATE_CYC), longint'(RATE_DIV));
        localparam longint MARGIN = band_margin(NOM);
        localparam logic [63:0] LO = 64'(NOM - MARGIN);
        localparam logic [63:0] HI = 64'(NOM + MARGIN);
        if (NOM >= MIN_NOMINAL) begin : g_on
            assign in_band[k] = (cnt_wide >= LO) && (cnt_wide <= HI);
        end else begin : g_off
            assign in_band[k] = 1'b0;
        end
    end

    // lowest matching code wins when bands overlap
    always_comb begin
        cls = '0;
        for (int k = NUM_CLASSES; k >= 1; k--) begin
            if (in_band[k]) cls = CODE_W'(k);
        end
    end

    assign hit = |in_band;

endmodule

// File: rtl/refclk_rate_classifier.sv
module refclk_rate_classifier
    import rate_cls_pkg::*;
#(
    parameter int GATE_CYC_10M = 10000,
    parameter int RATE_DIV     = 1
) (
    input  logic       clk_m,
    input  logic       rst_n,
    input  logic       mclk_fast,
    input  logic       ref_in,
    output logic [2:0] rate_code,
    output logic       rate_valid,
    output logic       rate_changed
);

    localparam int GATE_SLOW = GATE_CYC_10M;
    localparam int GATE_FAST = 2 * GATE_CYC_10M;
    localparam int CNT_W     = $clog2(GATE_FAST + 1);

    win_state_t       state, state_nx;
    logic             win_load;
    logic             win_run;
    logic             gate_last;
    logic [CNT_W-1:0] edge_cnt;
    rate_code_t       match_cls;
    logic             match_hit;
    rate_code_t       last_good;

    assign win_load = (state == ST_ARM) || (state == ST_JUDGE);
    assign win_run  = (state == ST_GATE);

    rate_gate_timer #(
        .SLOW_CYC (GATE_SLOW),
        .FAST_CYC (GATE_FAST)
    ) u_timer (
        .clk   (clk_m),
        .rst_n (rst_n),
        .load  (win_load),
        .run   (win_run),
        .fast  (mclk_fast),
        .last  (gate_last)
    );

    rate_edge_counter #(
        .CNT_W (CNT_W)
    ) u_edges (
        .clk       (clk_m),
        .rst_n     (rst_n),
        .ref_async (ref_in),
        .clr       (win_load),
        .en        (win_run),
        .count     (edge_cnt)
    );

    rate_band_match #(
        .CNT_W    (CNT_W),
        .GATE_CYC (GATE_CYC_10M),
        .RATE_DIV (RATE_DIV)
    ) u_match (
        .count (edge_cnt),
        .cls   (match_cls),
        .hit   (match_hit)
    );

    // state register
    always_ff @(posedge clk_m or negedge rst_n) begin
        if (!rst_n) state <= ST_ARM;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARM:   state_nx = ST_GATE;
            ST_GATE:  if (gate_last) state_nx = ST_JUDGE;
            ST_JUDGE: state_nx = ST_GATE;
            default:  state_nx = ST_ARM;
        endcase
    end

    // outputs: verdict registered in the judge cycle
    always_ff @(posedge clk_m or negedge rst_n) begin
        if (!rst_n) begin
            rate_code    <= '0;
            rate_valid   <= 1'b0;
            rate_changed <= 1'b0;
            last_good    <= '0;
        end else begin
            rate_changed <= 1'b0;
            if (state == ST_JUDGE) begin
                if (match_hit) begin
                    rate_code    <= match_cls;
                    rate_valid   <= 1'b1;
                    rate_changed <= (last_good != '0) && (last_good != match_cls);
                    last_good    <= match_cls;
                end else begin
                    rate_code    <= '0;
                    rate_valid   <= 1'b0;
                end
            end
        end
    end

    // R7: a change pulse only follows a judge cycle
    assert_pulse_after_judge_R7: assert property (@(posedge clk_m) disable iff (!rst_n)
        rate_changed |-> $past(state == ST_JUDGE));

    // R7: a change pulse always comes with a valid nonzero code
    assert_pulse_with_valid_R7: assert property (@(posedge clk_m) disable iff (!rst_n)
        rate_changed |-> (rate_valid && (rate_code != '0)));

    // R5: valid flag and code agree
    assert_valid_code_R5: assert property (@(posedge clk_m) disable iff (!rst_n)
        (rate_valid == (rate_code != '0)));

    // R6: outputs hold unless the previous cycle was a judge cycle
    assert_hold_R6: assert property (@(posedge clk_m) disable iff (!rst_n)
        !$past(state == ST_JUDGE) |-> ($stable(rate_code) && $stable(rate_valid)));

endmodule

// File: tb/tb_refclk_rate_classifier.sv
`timescale 1ns/1ps
module tb_refclk_rate_classifier;

    localparam int  G       = 4000;
    localparam int  DIV     = 50;
    localparam real CLK_NS  = 4.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclk_fast = 1'b0;
    logic       ref_in;
    logic [2:0] rate_code;
    logic       rate_valid;
    logic       rate_changed;

    int  n_cmp = 0;
    int  n_bad = 0;
    real half_ns = 0.0;

    int    q_code[$];
    int    q_valid[$];
    int    q_chg[$];
    string q_req[$];
    event  win_evt;

    refclk_rate_classifier #(
        .GATE_CYC_10M (G),
        .RATE_DIV     (DIV)
    ) dut (
        .clk_m        (clk),
        .rst_n        (rst_n),
        .mclk_fast    (mclk_fast),
        .ref_in       (ref_in),
        .rate_code    (rate_code),
        .rate_valid   (rate_valid),
        .rate_changed (rate_changed)
    );

    always #(CLK_NS / 2.0) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference generator: half period in ns, 0 holds the line low
    initial begin
        real cur, nxt, step;
        ref_in = 1'b0;
        forever begin
            if (half_ns <= 0.0) begin
                ref_in = 1'b0;
                #1;
            end else begin
                cur = half_ns;
                nxt = $realtime + cur;
                while ((half_ns == cur) && ((nxt - $realtime) > 0.001)) begin
                    step = nxt - $realtime;
                    if (step > 8.0) step = 8.0;
                    #(step);
                end
                if (half_ns == cur) ref_in = ~ref_in;
            end
        end
    end

    task automatic set_ref(input real f_hz);
        real fm;
        fm = mclk_fast ? 20.0e6 : 10.0e6;
        if (f_hz <= 0.0) half_ns = 0.0;
        else             half_ns = CLK_NS * fm / (2.0 * (f_hz / real'(DIV)));
    endtask

    // driver: apply a reference, queue the expected verdicts, wait them out
    task automatic run(input real f_hz, input int code, input int valid, input int chg_first,
                       input int nwin, input string req);
        set_ref(f_hz);
        for (int i = 0; i < nwin; i++) begin
            q_code.push_back(code);
            q_valid.push_back(valid);
            q_chg.push_back((i == 0) ? chg_first : 0);
            q_req.push_back(req);
        end
        repeat (nwin) @(win_evt);
    endtask

    // monitor: fixed verdict schedule from reset release
    initial begin
        int n_win, gap, last_code, last_valid, e_code, e_valid, e_chg;
        string e_req;
        forever begin
            @(posedge rst_n);
            n_win = mclk_fast ? 2 * G : G;
            @(negedge clk);
            last_code  = 0;
            last_valid = 0;
            gap = n_win;
            forever begin
                repeat (gap) @(negedge clk);
                if (!rst_n) break;
                check("R2 R6", "code before verdict edge", int'(rate_code), last_code);
                check("R2 R6", "valid before verdict edge", int'(rate_valid), last_valid);
                check("R2 R7", "pulse before verdict edge", int'(rate_changed), 0);
                @(negedge clk);
                if (!rst_n) break;
                if (q_code.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R2: verdict with empty scoreboard got %0d expected none",
                             int'(rate_code));
                end else begin
                    e_code  = q_code.pop_front();
                    e_valid = q_valid.pop_front();
                    e_chg   = q_chg.pop_front();
                    e_req   = q_req.pop_front();
                    check(e_req, "rate_code", int'(rate_code), e_code);
                    check(e_req, "rate_valid", int'(rate_valid), e_valid);
                    check(e_req, "rate_changed", int'(rate_changed), e_chg);
                    last_code  = e_code;
                    last_valid = e_valid;
                end
                -> win_evt;
                @(negedge clk);
                if (!rst_n) break;
                check("R7", "pulse one cycle after verdict", int'(rate_changed), 0);
                repeat (n_win / 2 - 1) @(negedge clk);
                if (!rst_n) break;
                check("R6", "code mid-window", int'(rate_code), last_code);
                check("R6", "valid mid-window", int'(rate_valid), last_valid);
                gap = n_win - n_win / 2;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run still busy got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // phase 1: 10 MHz master
        set_ref(0.0);
        repeat (10) @(negedge clk);
        check("R1", "code in reset", int'(rate_code), 0);
        check("R1", "valid in reset", int'(rate_valid), 0);
        check("R1", "pulse in reset", int'(rate_changed), 0);
        rst_n = 1'b1;
        check("R1", "code after release", int'(rate_code), 0);
        run(0.0,            0, 0, 0, 1, "R5 no reference");
        run(19.44e6,        5, 1, 0, 2, "R3 R10 first valid no pulse R7");
        run(38.88e6,        6, 1, 1, 2, "R3 R7 direct change");
        run(0.0,            0, 0, 0, 2, "R5 R8 gap");
        run(38.88e6,        6, 1, 0, 1, "R8 same after gap");
        run(0.0,            0, 0, 0, 1, "R5 R8 gap");
        run(1.544e6,        3, 1, 1, 2, "R3 R8 new after gap");
        run(0.0,            0, 0, 0, 1, "R5 gap");
        run(2.048e6,        4, 1, 1, 1, "R3 R10 change");
        run(77.76e6*1.005,  7, 1, 1, 1, "R4 plus half percent");
        run(77.76e6*0.97,   0, 0, 0, 1, "R4 minus three percent");
        run(8.0e6,          0, 0, 0, 1, "R5 between classes");
        run(77.76e6,        7, 1, 0, 1, "R3 R8 same class");
        run(8.0e3,          0, 0, 0, 1, "R5 disabled class");
        // phase 2: 20 MHz master
        rst_n = 1'b0;
        mclk_fast = 1'b1;
        set_ref(19.44e6);
        repeat (10) @(negedge clk);
        check("R1", "code in reset fast", int'(rate_code), 0);
        check("R1", "valid in reset fast", int'(rate_valid), 0);
        rst_n = 1'b1;
        run(19.44e6,        5, 1, 0, 1, "R9 R2 first window");
        run(77.76e6,        7, 1, 1, 1, "R9 R7");
        run(0.0,            0, 0, 0, 1, "R9 R5");
        run(1.544e6,        3, 1, 1, 1, "R9 R8");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule